// File: doc/BRIEF.md
# Programmed-I/O Data Port with Request Handshake

This block lets a CPU move a counted run of bytes into or out of a small internal byte buffer by plain loads and stores, paced by a data-request line. A controller arms the port with a buffer index to begin at, a byte count, and a flag that says whether it wants to be told when the run is over. Arming raises the request line when the count is not zero. The CPU then reads or writes the port with single-byte or two-byte accesses. Two-byte accesses carry the earlier buffer byte in the upper half of the 16-bit data word, so the pair is big-endian.

Writes also count down a transfer counter shared with the rest of the controller. The counter is loaded through its own strobe. A write is dropped entirely while that counter is zero or no bytes are left. Reads never touch the counter. When the byte count runs out and notification was requested, the request line drops and a single-cycle done pulse fires, together with the number of bytes moved in the run.

Top module: `pdma_port`

## Requirements
- R1: Out of reset the request line, the done pulse, the transfer counter and the read data are all zero.
- R2: An arm strobe sets the current buffer index to the given start index, stores the byte count and the notify flag, restarts the moved-byte tally, and sets the request line to one exactly when the count is non-zero.
- R3: An accepted 1-byte write (size code 1) stores data bits 7:0 at the current index, then advances the index by one and lowers both the remaining count and the transfer counter by one.
- R4: An accepted 2-byte write (size code 2) with at least two bytes left stores data bits 15:8 at the current index and bits 7:0 at the following index, then advances the index by two and lowers the count and the transfer counter by two.
- R5: A write while the transfer counter is zero or the remaining count is zero changes no buffer byte, no index, no count and no counter, and raises no done pulse.
- R6: A 1-byte read returns the byte at the current index in bits 7:0 with bits 15:8 zero; a 2-byte read with at least two bytes left returns the byte at the current index in bits 15:8 and the next byte in bits 7:0. Read data is valid in the cycle of the access; each read advances the index and lowers the count by the bytes moved but leaves the transfer counter unchanged.
- R7: A read while the remaining count is zero returns 0 and changes no state.
- R8: When an access brings the remaining count to zero and notification is armed, the request line is low and the done pulse is high for exactly one cycle starting the cycle after that access, the done count equals the bytes moved since arming, and notification is disarmed; without notification the request line stays high and no pulse fires.
- R9: Accesses with size code 0 or 3 are ignored: no data is stored, no state changes and the read data is 0.
- R10: A 2-byte access when only one byte is left moves one byte: a write stores only bits 15:8, a read returns that byte in bits 15:8 with bits 7:0 zero, and the count reaches zero.
- R11: The transfer counter never wraps below zero: a write that moves more bytes than the counter holds leaves it at zero; the buffer index wraps modulo the buffer depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armValid | input | 1 | Arm strobe from the controller |
| armStart | input | IDX_W | Start index in the buffer |
| armLen | input | LEN_W | Number of bytes to move |
| armNotify | input | 1 | Request a done pulse when the count runs out |
| tcLoad | input | 1 | Load strobe for the transfer counter |
| tcLoadValue | input | TC_W | Value loaded into the transfer counter |
| accValid | input | 1 | CPU access strobe |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accSize | input | 2 | Access size code: 1 byte or 2 bytes |
| accWdata | input | 16 | Write data |
| accRdata | output | 16 | Read data, valid in the access cycle |
| drq | output | 1 | Data request to the CPU |
| donePulse | output | 1 | One-cycle completion pulse to the controller |
| doneCount | output | LEN_W | Bytes moved in the finished run |
| tcValue | output | TC_W | Current transfer counter |

## Verification
The assertions assume that an arm strobe never coincides with a CPU access, and that a counter load never coincides with a write; the block resolves those collisions, but the properties on counter movement and ignored accesses are only stated for the clean case. The bench drives exactly one of arm, load or access in any cycle through separate tasks, so it never leaves that space. Within it, the bench sweeps every start index, run lengths that cross the buffer end, and both byte and halfword sizes in each direction, keeping a byte model of the buffer and an arithmetic model of the counter.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic arm;     // load index and restart tally
    logic wrMove;  // accepted write moves bytes this cycle
    logic rdMove;  // accepted read moves bytes this cycle
    logic wide;    // a 2-byte access was requested
    logic pair;    // two bytes actually move
    logic finish;  // run completes with notification
  } pdmaStrobe_t;

endpackage

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armValid,
  input  logic [LEN_W-1:0] armLen,
  input  logic             armNotify,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [1:0]       accSize,
  input  logic             tcZero,
  output pdmaStrobe_t      strobe,
  output logic             drq,
  output logic             donePulse
);

  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] lenNext;
  logic [LEN_W-1:0] stepLen;
  logic             notifyQ;
  logic             drqQ;
  logic             doneQ;
  logic             sizeOk;
  logic             live;
  logic             wrOk;
  logic             rdOk;

  always_comb begin
    sizeOk  = (accSize == 2'd1) || (accSize == 2'd2);
    live    = accValid && sizeOk && !armValid && (lenQ != '0);
    wrOk    = live && accWrite && !tcZero;
    rdOk    = live && !accWrite;
    strobe.arm    = armValid;
    strobe.wrMove = wrOk;
    strobe.rdMove = rdOk;
    strobe.wide   = (accSize == 2'd2);
    strobe.pair   = (accSize == 2'd2) && (lenQ >= LEN_W'(2));
    stepLen = strobe.pair ? LEN_W'(2) : LEN_W'(1);
    lenNext = lenQ - stepLen;
    strobe.finish = (wrOk || rdOk) && (lenNext == '0) && notifyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ    <= '0;
      notifyQ <= 1'b0;
      drqQ    <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= strobe.finish;
      if (armValid) begin
        lenQ    <= armLen;
        notifyQ <= armNotify;
        drqQ    <= (armLen != '0);
      end else if (wrOk || rdOk) begin
        lenQ <= lenNext;
        if (strobe.finish) begin
          notifyQ <= 1'b0;
          drqQ    <= 1'b0;
        end
      end
    end
  end

  assign drq       = drqQ;
  assign donePulse = doneQ;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R8
  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!notifyQ && !drqQ)); // R8
  AST_LEN_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    !armValid |=> (lenQ <= $past(lenQ))); // R3

endmodule

// File: rtl/pdma_datapath.sv
module pdma_datapath
  import pdma_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 16,
  parameter int TC_W  = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  pdmaStrobe_t      strobe,
  input  logic [IDX_W-1:0] armStart,
  input  logic [15:0]      accWdata,
  input  logic             tcLoad,
  input  logic [TC_W-1:0]  tcLoadValue,
  output logic [15:0]      accRdata,
  output logic [TC_W-1:0]  tcValue,
  output logic             tcZero,
  output logic [LEN_W-1:0] doneCount
);

  localparam int DEPTH = 1 << IDX_W;

  logic [7:0]       memQ [DEPTH];
  logic [IDX_W-1:0] curQ;
  logic [IDX_W-1:0] curNext1;
  logic [IDX_W-1:0] stepIdx;
  logic [LEN_W-1:0] stepLen;
  logic [TC_W-1:0]  stepTc;
  logic [LEN_W-1:0] movedQ;
  logic [LEN_W-1:0] doneCountQ;
  logic [TC_W-1:0]  tcQ;
  logic [7:0]       byte0;
  logic [7:0]       byte1;

  always_comb begin
    curNext1 = curQ + IDX_W'(1);
    stepIdx  = strobe.pair ? IDX_W'(2) : IDX_W'(1);
    stepLen  = strobe.pair ? LEN_W'(2) : LEN_W'(1);
    stepTc   = strobe.pair ? TC_W'(2)  : TC_W'(1);
    byte0    = memQ[curQ];
    byte1    = memQ[curNext1];
    if (!strobe.rdMove)    accRdata = 16'h0000;
    else if (!strobe.wide) accRdata = {8'h00, byte0};
    else if (strobe.pair)  accRdata = {byte0, byte1};
    else                   accRdata = {byte0, 8'h00};
  end

  // Buffer storage: no reset, contents are data only.
  always_ff @(posedge clk) begin
    if (strobe.wrMove) begin
      if (strobe.wide) begin
        memQ[curQ] <= accWdata[15:8];
        if (strobe.pair) memQ[curNext1] <= accWdata[7:0];
      end else begin
        memQ[curQ] <= accWdata[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ       <= '0;
      movedQ     <= '0;
      doneCountQ <= '0;
      tcQ        <= '0;
    end else begin
      if (strobe.arm) begin
        curQ   <= armStart;
        movedQ <= '0;
      end else if (strobe.wrMove || strobe.rdMove) begin
        curQ   <= curQ + stepIdx;
        movedQ <= movedQ + stepLen;
      end
      if (strobe.finish) doneCountQ <= movedQ + stepLen;
      if (tcLoad)
        tcQ <= tcLoadValue;
      else if (strobe.wrMove)
        tcQ <= (tcQ < stepTc) ? '0 : tcQ - stepTc;
    end
  end

  assign tcValue   = tcQ;
  assign tcZero    = (tcQ == '0);
  assign doneCount = doneCountQ;

  AST_READ_KEEPS_TC: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdMove && !tcLoad) |=> (tcQ == $past(tcQ))); // R6
  AST_TC_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrMove && !tcLoad) |=> (tcQ <= $past(tcQ))); // R11

endmodule

// File: rtl/pdma_port.sv
module pdma_port
  import pdma_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int LEN_W = 16,
  parameter int TC_W  = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armValid,
  input  logic [IDX_W-1:0] armStart,
  input  logic [LEN_W-1:0] armLen,
  input  logic             armNotify,
  input  logic             tcLoad,
  input  logic [TC_W-1:0]  tcLoadValue,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [1:0]       accSize,
  input  logic [15:0]      accWdata,
  output logic [15:0]      accRdata,
  output logic             drq,
  output logic             donePulse,
  output logic [LEN_W-1:0] doneCount,
  output logic [TC_W-1:0]  tcValue
);

  pdmaStrobe_t strobe;
  logic        tcZero;

  pdma_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .armValid  (armValid),
    .armLen    (armLen),
    .armNotify (armNotify),
    .accValid  (accValid),
    .accWrite  (accWrite),
    .accSize   (accSize),
    .tcZero    (tcZero),
    .strobe    (strobe),
    .drq       (drq),
    .donePulse (donePulse)
  );

  pdma_datapath #(.IDX_W(IDX_W), .LEN_W(LEN_W), .TC_W(TC_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .armStart    (armStart),
    .accWdata    (accWdata),
    .tcLoad      (tcLoad),
    .tcLoadValue (tcLoadValue),
    .accRdata    (accRdata),
    .tcValue     (tcValue),
    .tcZero      (tcZero),
    .doneCount   (doneCount)
  );

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && (tcValue == '0) && !tcLoad)
      |=> ((tcValue == '0) && !donePulse)); // R5
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (accSize != 2'd1) && (accSize != 2'd2) && !tcLoad)
      |=> ($stable(tcValue) && !donePulse)); // R9
  AST_DRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !drq); // R8

endmodule

// File: tb/sim_pdma_port.sv
`timescale 1ns/1ps
module sim_pdma_port;

  localparam int IDX_W = 4;
  localparam int LEN_W = 16;
  localparam int TC_W  = 24;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             armValid = 1'b0;
  logic [IDX_W-1:0] armStart = '0;
  logic [LEN_W-1:0] armLen = '0;
  logic             armNotify = 1'b0;
  logic             tcLoad = 1'b0;
  logic [TC_W-1:0]  tcLoadValue = '0;
  logic             accValid = 1'b0;
  logic             accWrite = 1'b0;
  logic [1:0]       accSize = 2'd0;
  logic [15:0]      accWdata = '0;
  logic [15:0]      accRdata;
  logic             drq;
  logic             donePulse;
  logic [LEN_W-1:0] doneCount;
  logic [TC_W-1:0]  tcValue;

  int nChecks = 0;
  int nErrors = 0;
  logic [7:0] refMem [DEPTH];
  int tcExp;

  always #2.5 clk = ~clk;

  pdma_port #(.IDX_W(IDX_W), .LEN_W(LEN_W), .TC_W(TC_W)) u0 (
    .clk(clk), .rstN(rstN), .armValid(armValid), .armStart(armStart),
    .armLen(armLen), .armNotify(armNotify), .tcLoad(tcLoad),
    .tcLoadValue(tcLoadValue), .accValid(accValid), .accWrite(accWrite),
    .accSize(accSize), .accWdata(accWdata), .accRdata(accRdata), .drq(drq),
    .donePulse(donePulse), .doneCount(doneCount), .tcValue(tcValue)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  // All tasks start and end just after a falling edge.
  task automatic doArm(input int start, input int len, input logic notify);
    armValid = 1'b1; armStart = IDX_W'(start); armLen = LEN_W'(len); armNotify = notify;
    @(posedge clk); @(negedge clk);
    armValid = 1'b0;
  endtask

  task automatic doLoad(input int v);
    tcLoad = 1'b1; tcLoadValue = TC_W'(v);
    @(posedge clk); @(negedge clk);
    tcLoad = 1'b0;
    tcExp = v;
  endtask

  task automatic doAcc(input logic wr, input logic [1:0] size,
                       input logic [15:0] data, output logic [15:0] rd);
    accValid = 1'b1; accWrite = wr; accSize = size; accWdata = data;
    #1 rd = accRdata;
    @(posedge clk); @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int s, input int l, input int k, input int m);
    return 8'((s * 7 + l * 13 + k * 29 + m * 5 + 3) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    for (int i = 0; i < DEPTH; i++) refMem[i] = 8'h00;
    tcExp = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "drq in reset", 32'(drq), 0);
    chk("R1", "done in reset", 32'(donePulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "drq after reset", 32'(drq), 0);
    chk("R1", "done after reset", 32'(donePulse), 0);
    chk("R1", "tc after reset", 32'(tcValue), 0);
    chk("R1", "rdata idle", 32'(accRdata), 0);

    // Zero-fill the buffer through the port so the model is exact.
    doLoad(100);
    doArm(0, DEPTH, 1'b1);
    chk("R2", "drq armed", 32'(drq), 1);
    for (int k = 0; k < DEPTH / 2; k++) doAcc(1'b1, 2'd2, 16'h0000, rd);
    chk("R8", "fill done pulse", 32'(donePulse), 1);
    chk("R8", "fill done count", 32'(doneCount), DEPTH);
    chk("R4", "fill tc", 32'(tcValue), 100 - DEPTH);
    idle();

    // Sweep: every start, lengths 1..5, two size mixes, write then read back.
    for (int s = 0; s < DEPTH; s++) begin
      for (int l = 1; l <= 5; l++) begin
        for (int m = 0; m < 2; m++) begin
          int idx;
          int rem;
          doLoad(1000 + s * 10 + l);
          doArm(s, l, 1'b1);
          idx = s; rem = l;
          while (rem > 0) begin
            int mv;
            logic [7:0] b0;
            logic [7:0] b1;
            b0 = pat(s, l, l - rem, m);
            b1 = pat(s, l, l - rem + 1, m);
            chk("R8", "drq before end", 32'(drq), 1);
            if (m == 0) begin
              doAcc(1'b1, 2'd1, {8'hC3, b0}, rd);
              refMem[idx] = b0; mv = 1;
            end else if (rem >= 2) begin
              doAcc(1'b1, 2'd2, {b0, b1}, rd);
              refMem[idx] = b0; refMem[(idx + 1) % DEPTH] = b1; mv = 2;
            end else begin
              doAcc(1'b1, 2'd2, {b0, 8'hEE}, rd); // R10: one byte moves
              refMem[idx] = b0; mv = 1;
            end
            idx = (idx + mv) % DEPTH; rem -= mv; tcExp -= mv;
            chk(m == 0 ? "R3" : "R4", "tc after write", 32'(tcValue), 32'(tcExp));
          end
          chk("R8", "write done pulse", 32'(donePulse), 1);
          chk("R8", "write done count", 32'(doneCount), 32'(l));
          chk("R8", "drq dropped", 32'(drq), 0);
          idle();
          chk("R8", "pulse single cycle", 32'(donePulse), 0);

          doArm(s, l, 1'b1);
          idx = s; rem = l;
          while (rem > 0) begin
            int mv;
            logic [15:0] ex;
            if (m == 1) begin
              doAcc(1'b0, 2'd1, 16'h0, rd); ex = {8'h00, refMem[idx]}; mv = 1;
            end else if (rem >= 2) begin
              doAcc(1'b0, 2'd2, 16'h0, rd);
              ex = {refMem[idx], refMem[(idx + 1) % DEPTH]}; mv = 2;
            end else begin
              doAcc(1'b0, 2'd2, 16'h0, rd); ex = {refMem[idx], 8'h00}; mv = 1; // R10
            end
            chk("R6", "read data (R11 wrap)", 32'(rd), 32'(ex));
            chk("R6", "tc unchanged by read", 32'(tcValue), 32'(tcExp));
            idx = (idx + mv) % DEPTH; rem -= mv;
          end
          chk("R8", "read done pulse", 32'(donePulse), 1);
          chk("R8", "read done count", 32'(doneCount), 32'(l));
          idle();
        end
      end
    end

    // R5: counter zero blocks writes.
    doLoad(0);
    doArm(2, 3, 1'b1);
    doAcc(1'b1, 2'd1, 16'h00A5, rd);
    chk("R5", "tc stays zero", 32'(tcValue), 0);
    chk("R5", "no pulse", 32'(donePulse), 0);
    chk("R5", "drq still up", 32'(drq), 1);
    doAcc(1'b0, 2'd1, 16'h0, rd);
    chk("R5", "index and byte untouched", 32'(rd), 32'({8'h00, refMem[2]}));

    // R9: bad size codes ignored.
    doLoad(50);
    doArm(4, 2, 1'b1);
    doAcc(1'b1, 2'd3, 16'h5A5A, rd);
    chk("R9", "size3 write tc", 32'(tcValue), 50);
    doAcc(1'b0, 2'd0, 16'h0, rd);
    chk("R9", "size0 read data", 32'(rd), 0);
    doAcc(1'b0, 2'd2, 16'h0, rd);
    chk("R9", "index unchanged", 32'(rd), 32'({refMem[4], refMem[5]}));
    chk("R9", "pulse after good read", 32'(donePulse), 1);
    idle();

    // R7 / R2: zero-length arm.
    doArm(6, 0, 1'b1);
    chk("R2", "drq low on zero length", 32'(drq), 0);
    doAcc(1'b0, 2'd2, 16'h0, rd);
    chk("R7", "read with nothing left", 32'(rd), 0);
    chk("R7", "no pulse", 32'(donePulse), 0);
    doAcc(1'b1, 2'd1, 16'h0011, rd);
    chk("R5", "write with nothing left tc", 32'(tcValue), 50);

    // R8: no notification.
    doArm(8, 1, 1'b0);
    doAcc(1'b0, 2'd1, 16'h0, rd);
    chk("R8", "no-notify data", 32'(rd), 32'({8'h00, refMem[8]}));
    chk("R8", "no-notify no pulse", 32'(donePulse), 0);
    chk("R8", "no-notify drq high", 32'(drq), 1);

    // R11: counter saturates.
    doLoad(1);
    doArm(0, 4, 1'b1);
    doAcc(1'b1, 2'd2, 16'h1234, rd);
    refMem[0] = 8'h12; refMem[1] = 8'h34;
    chk("R11", "tc saturated", 32'(tcValue), 0);
    doAcc(1'b1, 2'd2, 16'h5678, rd);
    chk("R11", "write blocked after saturation", 32'(tcValue), 0);
    doArm(0, 3, 1'b1);
    doAcc(1'b0, 2'd2, 16'h0, rd);
    chk("R11", "stored pair", 32'(rd), 32'h1234);
    doAcc(1'b0, 2'd1, 16'h0, rd);
    chk("R11", "next byte untouched", 32'(rd), 32'({8'h00, refMem[2]}));
    chk("R8", "final pulse", 32'(donePulse), 1);
    chk("R8", "final count", 32'(doneCount), 3);

    summary();
    $finish;
  end

endmodule